// File: doc/BRIEF.md
# Pipeline Stall and Redirect Controller

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It watches the decode and execute stages and drives the enables, clears and next-PC select that the datapath uses to stall, squash and redirect. It has three jobs.

The first is the load-use bubble. When a load in execute writes a register that the instruction in decode reads, forwarding cannot supply the value in time. The controller freezes the PC and the fetch/decode register for one cycle and clears the control bits going into execute.

The second is redirection. Branches are resolved in decode and assumed not taken, so a taken branch or any jump costs exactly one squashed fetch. The third is trap entry. Execute overflow, decode illegal-opcode and an external interrupt request are ranked oldest-first, with the interrupt last. The controller then squashes the younger stages, records a return address and a cause code, and steers fetch to a fixed handler address.

The datapath is outside the block. Every pin is a plain, single-cycle control or status signal with no handshake: the decode and execute stages present their fields each cycle, and the controller answers combinationally in the same cycle. Only the saved return address and the cause code are registered.

Top module: `hazard_ctrl`

## Requirements
- R1: When `exe_mem_read` is 1, `exe_rt` is nonzero, and it equals `dec_rs` with `dec_rs_used`=1 or `dec_rt` with `dec_rt_used`=1, and no trap is taken, the outputs are `pc_en`=0, `fd_en`=0, `de_clear`=1, `fd_clear`=0, `em_clear`=0 and `pc_sel`=0.
- R2: No stall occurs in three cases: the execute instruction is not a load, its destination is register 0, or the matching source is flagged unused. Apart from a redirect or trap, the outputs are then `pc_en`=1, `fd_en`=1, all clears 0 and `pc_sel`=0 (sequential).
- R3: A decode branch with `dec_operands_equal`=1, and no stall or trap, gives `pc_sel`=1 (branch target) and `fd_clear`=1. With `dec_operands_equal`=0 it gives sequential fetch with no clear.
- R4: A decode jump, with no stall or trap, gives `pc_sel`=2 (jump target) and `fd_clear`=1. This penalty is always exactly one squashed fetch.
- R5: A taken branch whose sources hit the pending load does not redirect in that cycle: the R1 stall outputs apply and `pc_sel`=0.
- R6: `exe_overflow`=1 overrides everything. The outputs are `pc_sel`=3, `pc_en`=1, `fd_en`=1, and `fd_clear`, `de_clear` and `em_clear` all 1. After the clock edge, `epc` equals `exe_pc`+4 and `cause`=1.
- R7: `dec_illegal`=1 without an overflow gives `pc_sel`=3, `fd_clear`=1, `de_clear`=1 and `em_clear`=0, so the execute instruction completes. After the edge, `epc`=`dec_pc`+4 and `cause`=2.
- R8: `irq_req` is taken only when `dec_valid`=1 and neither other trap is present. It then acts like R7, but stores `cause`=3. When `dec_valid`=0 it has no effect on any output.
- R9: After reset, `epc`=0 and `cause`=0. Both hold their value in every cycle that takes no trap.
- R10: `trap_pc` equals the handler address parameter, 32'h4000_0040 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_rs | input | REG_W | First source register of the decode instruction |
| dec_rt | input | REG_W | Second source register of the decode instruction |
| dec_rs_used | input | 1 | Decode instruction reads `dec_rs` |
| dec_rt_used | input | 1 | Decode instruction reads `dec_rt` |
| dec_valid | input | 1 | Decode holds a real instruction (not a bubble) |
| dec_branch | input | 1 | Decode instruction is a branch-on-equal |
| dec_jump | input | 1 | Decode instruction is a jump |
| dec_operands_equal | input | 1 | Decode-stage comparator result |
| dec_illegal | input | 1 | Decode found an undefined opcode |
| dec_pc | input | PC_W | PC of the decode instruction |
| exe_mem_read | input | 1 | Execute instruction is a load |
| exe_rt | input | REG_W | Destination register of the execute load |
| exe_overflow | input | 1 | Execute raised arithmetic overflow |
| exe_pc | input | PC_W | PC of the execute instruction |
| irq_req | input | 1 | External interrupt request |
| pc_en | output | 1 | PC write enable |
| fd_en | output | 1 | Fetch/decode register write enable |
| fd_clear | output | 1 | Turn the fetch/decode instruction into a no-op |
| de_clear | output | 1 | Zero the control bits entering execute |
| em_clear | output | 1 | Zero the control bits entering memory |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 branch, 2 jump, 3 handler |
| trap_pc | output | PC_W | Handler address |
| epc | output | PC_W | Saved return address (faulting PC + 4) |
| cause | output | 2 | Last trap cause: 0 none, 1 overflow, 2 illegal, 3 interrupt |

## Verification
The hardest cases to reach are the collisions between events in the same cycle. Examples are a taken branch whose source register is the pending load's destination, and an overflow in execute together with an illegal opcode and an interrupt. Another is an interrupt that arrives while decode holds a bubble. Purely random inputs hit these only rarely. The stimulus therefore draws register numbers from a tiny pool so that source/destination matches are common. It also places each collision as a directed cycle before the random run.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_BRANCH = 2'd1,
    PCS_JUMP   = 2'd2,
    PCS_TRAP   = 2'd3
  } pc_sel_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_OVF     = 2'd1,
    CAUSE_ILLEGAL = 2'd2,
    CAUSE_IRQ     = 2'd3
  } cause_e;

  // number of source operands a decode instruction may read
  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSRC  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC*REG_W-1:0] src_idx,
  input  logic [NSRC-1:0]       src_used,
  input  logic                  ld_pending,
  input  logic [REG_W-1:0]      ld_dst,
  output logic                  hazard
);

  logic [NSRC-1:0] hit;
  logic            dst_live;

  // register 0 is hard-wired, so a load into it never creates a dependency
  assign dst_live = ld_pending && (ld_dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_used[g] && (src_idx[g*REG_W +: REG_W] == ld_dst);
  end

  assign hazard = dst_live && (|hit);

  // a bubble is only ever requested for a load whose destination is live
  assert_stall_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (ld_pending && ld_dst != '0));

endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect (
  input  logic clk,
  input  logic rst_n,
  input  logic is_branch,
  input  logic is_jump,
  input  logic operands_equal,
  input  logic hold,
  output logic take_branch,
  output logic take_jump
);

  logic br_resolved_taken;

  // branch resolves in decode; a pending load on its sources defers it
  assign br_resolved_taken = is_branch && operands_equal;
  assign take_branch       = br_resolved_taken && !hold;
  assign take_jump         = is_jump && !br_resolved_taken && !hold;

  assert_one_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_branch && take_jump));

  assert_hold_blocks_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !take_branch);

endmodule

// File: rtl/hzd_trap.sv
module hzd_trap
  import hazard_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exe_overflow,
  input  logic            dec_illegal,
  input  logic            irq_req,
  input  logic            dec_valid,
  input  logic [PC_W-1:0] dec_pc,
  input  logic [PC_W-1:0] exe_pc,
  output logic            trap_exe,
  output logic            trap_dec,
  output logic [PC_W-1:0] epc_q,
  output cause_e          cause_q
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic            irq_ok;
  cause_e          cause_d;
  logic [PC_W-1:0] epc_d;

  // the interrupt waits for a real instruction boundary and ranks last
  assign irq_ok   = irq_req && dec_valid;
  assign trap_exe = exe_overflow;
  assign trap_dec = !exe_overflow && (dec_illegal || irq_ok);

  always_comb begin
    cause_d = cause_q;
    epc_d   = epc_q;
    if (trap_exe) begin
      cause_d = CAUSE_OVF;
      epc_d   = exe_pc + PC_STEP;
    end else if (dec_illegal) begin
      cause_d = CAUSE_ILLEGAL;
      epc_d   = dec_pc + PC_STEP;
    end else if (irq_ok) begin
      cause_d = CAUSE_IRQ;
      epc_d   = dec_pc + PC_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  assert_ovf_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exe_overflow |=> (cause_q == CAUSE_OVF) && (epc_q == $past(exe_pc) + PC_STEP));

  assert_illegal_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_illegal && !exe_overflow) |=> (cause_q == CAUSE_ILLEGAL) &&
                                       (epc_q == $past(dec_pc) + PC_STEP));

  assert_irq_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (exe_overflow || dec_illegal)) |=> cause_q != CAUSE_IRQ);

  assert_state_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(exe_overflow || dec_illegal || (irq_req && dec_valid)) |=>
      ($stable(epc_q) && $stable(cause_q)));

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned     REG_W      = 5,
  parameter int unsigned     PC_W       = 32,
  parameter logic [PC_W-1:0] TRAP_ADDR  = 32'h4000_0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic             dec_rs_used,
  input  logic             dec_rt_used,
  input  logic             dec_valid,
  input  logic             dec_branch,
  input  logic             dec_jump,
  input  logic             dec_operands_equal,
  input  logic             dec_illegal,
  input  logic [PC_W-1:0]  dec_pc,
  input  logic             exe_mem_read,
  input  logic [REG_W-1:0] exe_rt,
  input  logic             exe_overflow,
  input  logic [PC_W-1:0]  exe_pc,
  input  logic             irq_req,
  output logic             pc_en,
  output logic             fd_en,
  output logic             fd_clear,
  output logic             de_clear,
  output logic             em_clear,
  output logic [1:0]       pc_sel,
  output logic [PC_W-1:0]  trap_pc,
  output logic [PC_W-1:0]  epc,
  output logic [1:0]       cause
);

  localparam int unsigned NSRC = NUM_SRC;

  logic                  ld_hazard;
  logic                  take_branch;
  logic                  take_jump;
  logic                  trap_exe;
  logic                  trap_dec;
  logic [PC_W-1:0]       epc_q;
  cause_e                cause_q;
  pc_sel_e               sel;
  logic [NSRC*REG_W-1:0] src_idx;
  logic [NSRC-1:0]       src_used;

  assign src_idx  = {dec_rt, dec_rs};
  assign src_used = {dec_rt_used, dec_rs_used};

  hzd_loaduse #(
    .REG_W (REG_W),
    .NSRC  (NSRC)
  ) u_loaduse (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_idx    (src_idx),
    .src_used   (src_used),
    .ld_pending (exe_mem_read),
    .ld_dst     (exe_rt),
    .hazard     (ld_hazard)
  );

  hzd_redirect u_redirect (
    .clk            (clk),
    .rst_n          (rst_n),
    .is_branch      (dec_branch),
    .is_jump        (dec_jump),
    .operands_equal (dec_operands_equal),
    .hold           (ld_hazard),
    .take_branch    (take_branch),
    .take_jump      (take_jump)
  );

  hzd_trap #(
    .PC_W (PC_W)
  ) u_trap (
    .clk          (clk),
    .rst_n        (rst_n),
    .exe_overflow (exe_overflow),
    .dec_illegal  (dec_illegal),
    .irq_req      (irq_req),
    .dec_valid    (dec_valid),
    .dec_pc       (dec_pc),
    .exe_pc       (exe_pc),
    .trap_exe     (trap_exe),
    .trap_dec     (trap_dec),
    .epc_q        (epc_q),
    .cause_q      (cause_q)
  );

  // priority: trap > load-use stall > branch > jump > sequential
  always_comb begin
    pc_en    = 1'b1;
    fd_en    = 1'b1;
    fd_clear = 1'b0;
    de_clear = 1'b0;
    em_clear = 1'b0;
    sel      = PCS_SEQ;
    if (trap_exe || trap_dec) begin
      sel      = PCS_TRAP;
      fd_clear = 1'b1;
      de_clear = 1'b1;
      em_clear = trap_exe;
    end else if (ld_hazard) begin
      pc_en    = 1'b0;
      fd_en    = 1'b0;
      de_clear = 1'b1;
    end else if (take_branch) begin
      sel      = PCS_BRANCH;
      fd_clear = 1'b1;
    end else if (take_jump) begin
      sel      = PCS_JUMP;
      fd_clear = 1'b1;
    end
  end

  assign pc_sel  = sel;
  assign trap_pc = TRAP_ADDR;
  assign epc     = epc_q;
  assign cause   = cause_q;

  assert_freeze_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en != fd_en) == 1'b0);

  assert_frozen_bubbles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |-> (de_clear && !fd_clear && pc_sel == PCS_SEQ));

  assert_redirect_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel == PCS_BRANCH || pc_sel == PCS_JUMP) |-> (fd_clear && pc_en && !de_clear));

  assert_stall_defers_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hazard && !exe_overflow && !dec_illegal && !(irq_req && dec_valid))
      |-> pc_sel == PCS_SEQ);

  assert_exe_flush_only_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    em_clear |-> (pc_sel == PCS_TRAP && fd_clear && de_clear && pc_en));

  assert_irq_needs_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !dec_valid && !exe_overflow && !dec_illegal) |-> pc_sel != PCS_TRAP);

endmodule

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;

  localparam int unsigned REG_W = 5;
  localparam int unsigned PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [REG_W-1:0] dec_rs = '0, dec_rt = '0, exe_rt = '0;
  logic             dec_rs_used = 0, dec_rt_used = 0, dec_valid = 0;
  logic             dec_branch = 0, dec_jump = 0, dec_operands_equal = 0;
  logic             dec_illegal = 0, exe_mem_read = 0, exe_overflow = 0, irq_req = 0;
  logic [PC_W-1:0]  dec_pc = '0, exe_pc = '0;
  logic             pc_en, fd_en, fd_clear, de_clear, em_clear;
  logic [1:0]       pc_sel, cause;
  logic [PC_W-1:0]  trap_pc, epc;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;

  logic [PC_W-1:0] m_epc   = '0;
  logic [1:0]      m_cause = 2'd0;
  string           reg_tag = "R9";

  always #5 clk = ~clk;

  hazard_ctrl u_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_rs_used(dec_rs_used), .dec_rt_used(dec_rt_used),
    .dec_valid(dec_valid), .dec_branch(dec_branch), .dec_jump(dec_jump),
    .dec_operands_equal(dec_operands_equal), .dec_illegal(dec_illegal),
    .dec_pc(dec_pc), .exe_mem_read(exe_mem_read), .exe_rt(exe_rt),
    .exe_overflow(exe_overflow), .exe_pc(exe_pc), .irq_req(irq_req),
    .pc_en(pc_en), .fd_en(fd_en), .fd_clear(fd_clear), .de_clear(de_clear),
    .em_clear(em_clear), .pc_sel(pc_sel), .trap_pc(trap_pc),
    .epc(epc), .cause(cause)
  );

  task automatic check(input string req, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected combinational response, packed as {pc_en,fd_en,fd_clr,de_clr,em_clr,sel[1:0]}
  function automatic logic [6:0] model_comb();
    logic hz, tx, td;
    hz = exe_mem_read && exe_rt != 0 &&
         ((dec_rs_used && dec_rs == exe_rt) || (dec_rt_used && dec_rt == exe_rt));
    tx = exe_overflow;
    td = !exe_overflow && (dec_illegal || (irq_req && dec_valid));
    if (tx)                                return 7'b11_111_11;
    if (td)                                return 7'b11_110_11;
    if (hz)                                return 7'b00_010_00;
    if (dec_branch && dec_operands_equal)  return 7'b11_100_01;
    if (dec_jump)                          return 7'b11_100_10;
    return 7'b11_000_00;
  endfunction

  function automatic string tag_comb();
    logic hz;
    hz = exe_mem_read && exe_rt != 0 &&
         ((dec_rs_used && dec_rs == exe_rt) || (dec_rt_used && dec_rt == exe_rt));
    if (exe_overflow) return "R6";
    if (dec_illegal) return "R7";
    if (irq_req) return "R8";
    if (hz && dec_branch) return "R5";
    if (hz) return "R1";
    if (dec_branch) return "R3";
    if (dec_jump) return "R4";
    return "R2";
  endfunction

  // one cycle: check registered state, apply inputs, check comb, predict next state
  task automatic step();
    logic [6:0] e;
    string t;
    check(reg_tag, "epc", epc, m_epc);
    check(reg_tag, "cause", {30'd0, cause}, {30'd0, m_cause});
    #1;
    e = model_comb();
    t = tag_comb();
    check(t, "pc_en", {31'd0, pc_en}, {31'd0, e[6]});
    check(t, "fd_en", {31'd0, fd_en}, {31'd0, e[5]});
    check(t, "fd_clear", {31'd0, fd_clear}, {31'd0, e[4]});
    check(t, "de_clear", {31'd0, de_clear}, {31'd0, e[3]});
    check(t, "em_clear", {31'd0, em_clear}, {31'd0, e[2]});
    check(t, "pc_sel", {30'd0, pc_sel}, {30'd0, e[1:0]});
    reg_tag = "R9";
    if (exe_overflow) begin
      m_epc = exe_pc + 4; m_cause = 2'd1; reg_tag = "R6";
    end else if (dec_illegal) begin
      m_epc = dec_pc + 4; m_cause = 2'd2; reg_tag = "R7";
    end else if (irq_req && dec_valid) begin
      m_epc = dec_pc + 4; m_cause = 2'd3; reg_tag = "R8";
    end else if (irq_req) begin
      reg_tag = "R8";
    end
    @(negedge clk);
  endtask

  task automatic idle();
    dec_rs = 0; dec_rt = 0; dec_rs_used = 0; dec_rt_used = 0; dec_valid = 1;
    dec_branch = 0; dec_jump = 0; dec_operands_equal = 0; dec_illegal = 0;
    exe_mem_read = 0; exe_rt = 0; exe_overflow = 0; irq_req = 0;
    dec_pc = 32'h0000_1000; exe_pc = 32'h0000_0ffc;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check("R9", "epc after reset", epc, '0);
    check("R9", "cause after reset", {30'd0, cause}, 32'd0);
    // R10 handler address
    check("R10", "trap_pc", trap_pc, 32'h4000_0040);

    // R1 load-use on rs then on rt
    idle(); exe_mem_read = 1; exe_rt = 5'd7; dec_rs = 5'd7; dec_rs_used = 1; step();
    idle(); exe_mem_read = 1; exe_rt = 5'd9; dec_rt = 5'd9; dec_rt_used = 1; step();
    // R2 load into r0, unused source, non-load
    idle(); exe_mem_read = 1; exe_rt = 5'd0; dec_rs = 5'd0; dec_rs_used = 1; step();
    idle(); exe_mem_read = 1; exe_rt = 5'd4; dec_rt = 5'd4; dec_rt_used = 0; step();
    idle(); exe_mem_read = 0; exe_rt = 5'd4; dec_rs = 5'd4; dec_rs_used = 1; step();
    // R3 taken and not taken
    idle(); dec_branch = 1; dec_operands_equal = 1; dec_rs_used = 1; dec_rt_used = 1; step();
    idle(); dec_branch = 1; dec_operands_equal = 0; step();
    // R4 jump
    idle(); dec_jump = 1; step();
    // R5 branch sourcing the pending load
    idle(); dec_branch = 1; dec_operands_equal = 1; dec_rs = 5'd3; dec_rs_used = 1;
    exe_mem_read = 1; exe_rt = 5'd3; step();
    // R6 all three trap sources at once
    idle(); exe_overflow = 1; dec_illegal = 1; irq_req = 1; exe_pc = 32'h0000_2000; step();
    // R7 illegal with interrupt
    idle(); dec_illegal = 1; irq_req = 1; dec_pc = 32'h0000_3000; step();
    // R8 interrupt while decode holds a bubble, then at a boundary
    idle(); irq_req = 1; dec_valid = 0; dec_jump = 1; step();
    idle(); irq_req = 1; dec_pc = 32'h0000_4440; step();
    idle(); step();

    // random phase with small register pool for frequent collisions
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int k;
      idle();
      dec_rs = 5'($urandom_range(0, 3));
      dec_rt = 5'($urandom_range(0, 3));
      exe_rt = 5'($urandom_range(0, 3));
      dec_rs_used = 1'($urandom_range(0, 1));
      dec_rt_used = 1'($urandom_range(0, 1));
      dec_valid = ($urandom_range(0, 5) != 0);
      exe_mem_read = 1'($urandom_range(0, 1));
      k = $urandom_range(0, 3);
      dec_branch = (k == 1);
      dec_jump = (k == 2);
      dec_operands_equal = 1'($urandom_range(0, 1));
      dec_illegal = ($urandom_range(0, 11) == 0);
      exe_overflow = ($urandom_range(0, 11) == 0);
      irq_req = ($urandom_range(0, 7) == 0);
      dec_pc = {$urandom_range(0, 32'h0fff_ffff), 2'b00};
      exe_pc = {$urandom_range(0, 32'h0fff_ffff), 2'b00};
      step();
    end
    idle(); step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule